// File: doc/BRIEF.md
# Trace buffer AXI write burst master

This block moves trace words from a small local write buffer into system memory as AXI4 incremental write bursts. Trace words enter through a valid/ready push port. The block gathers them until a full burst is ready, then sends the burst address, streams the data beats, and waits for the write response. Only after that response does it consider the next burst.

A control word sets three things: the maximum beats per burst, the AXI cache attribute bits and the protection attribute bits. This word is sampled when capture is enabled. The burst length is limited by the write buffer depth and by the memory region in use. In linear mode the region is one ring buffer that wraps at its end. In paged mode the region is a chain of 4 KB pages, and a burst never crosses a page boundary.

A stop request closes the input. The block then sends whatever data remains as shorter bursts. Once the last response has arrived, it returns to its idle state.

Top module: `tbuf_axi_burst_wr`

## Requirements
- R1: The 4-bit length setting N allows at most N+1 beats per burst, and AWLEN is always the burst's beat count minus one.
- R2: A burst never has more beats than the write buffer depth (WBUF_DEPTH), even when the length setting asks for more.
- R3: A burst never crosses the ring end BUF_BASE+BUF_BYTES when the paged-mode setting is 0, and never crosses a 4 KB boundary when it is 1. A burst is issued before a stop only when the buffer holds all of its beats.
- R4: After a stop request, the remaining buffered words go out in bursts no longer than the limits of R1 to R3, so the last burst may be short. A stop with an empty buffer issues no burst.
- R5: AWCACHE[3:0] equals the 4 cache setting bits and AWPROT[1:0] equals the 2 protection setting bits, with AWPROT[2]=0. AWSIZE is log2 of the bytes per beat and AWBURST is 2'b01 (INCR). After reset AWCACHE and AWPROT are 0.
- R6: Each enable starts at BUF_BASE, and each burst advances the address by 4 bytes (at DATA_W=32) times its beat count. In linear mode, reaching the ring end wraps the address to BUF_BASE; in paged mode it does not wrap.
- R7: Only one burst is outstanding: no new AW handshake occurs until the previous burst's B handshake has completed.
- R8: Once AWVALID or WVALID is raised, it stays high until its READY is seen, and the address, attributes, data and WLAST stay unchanged while stalled.
- R9: Write data leaves in the order it was pushed, each burst carries exactly AWLEN+1 beats, and WLAST is high only on the last beat.
- R10: The settings are sampled on the rising edge of the capture enable. Changing them while idle, or while a capture runs, has no effect on the traffic of that capture.
- R11: The idle flag is 1 after reset. It is 0 from the capture enable edge until the final response of the stop flush, and it is 1 again after that response.
- R12: The push port accepts words only while a capture runs, no stop is pending and the buffer has space. While idle it accepts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| capture_en | input | 1 | Rising edge starts a capture and samples the settings |
| stop_req | input | 1 | Stop request; flushes remaining data |
| cfg_burst_len | input | 4 | Burst length setting N (N+1 beats) |
| cfg_cache | input | 4 | Cache attribute setting |
| cfg_prot | input | 2 | Protection attribute setting |
| cfg_paged | input | 1 | 1 = 4 KB paged region, 0 = linear ring |
| in_valid | input | 1 | Trace word valid |
| in_data | input | DATA_W | Trace word |
| in_ready | output | 1 | Trace word accepted when high with in_valid |
| awvalid | output | 1 | Write address valid |
| awready | input | 1 | Write address ready |
| awaddr | output | ADDR_W | Burst start address |
| awlen | output | 8 | Beats minus one |
| awsize | output | 3 | log2 bytes per beat |
| awburst | output | 2 | Burst type, INCR |
| awcache | output | 4 | Cache attributes |
| awprot | output | 3 | Protection attributes |
| wvalid | output | 1 | Write data valid |
| wready | input | 1 | Write data ready |
| wdata | output | DATA_W | Write data |
| wstrb | output | DATA_W/8 | Byte strobes, all set |
| wlast | output | 1 | Last beat of the burst |
| bvalid | input | 1 | Write response valid |
| bready | output | 1 | Write response ready |
| idle | output | 1 | Idle / drained flag |

## Verification
Length settings of 1, 2, 3, 4 and 8 beats expose the N+1 decode. A setting of 16 beats against an 8-entry buffer exposes the depth clamp. Word counts that are and are not multiples of the burst length separate a full final burst from a short flush, and a capture with no data shows that an empty stop produces no traffic. One long capture per region mode tells the ring-end wrap apart from the 4 KB page cut, since the two modes split a burst at different addresses. A capture whose settings change mid-run, and an idle stretch with pushes offered, show that the settings are sampled only at the enable edge.

// File: rtl/tbm_pkg.sv
package tbm_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RUN,
        ST_ADDR,
        ST_DATA,
        ST_RESP
    } tbm_state_e;

    localparam logic [1:0] BURST_INCR = 2'b01;
    localparam int         BEAT_W     = 5;     // holds 1..16 beats
    localparam int         MAX_BEATS  = 16;
    localparam int         PAGE_BYTES = 4096;
endpackage

// File: rtl/tbm_wbuf.sv
module tbm_wbuf #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 8,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic [DATA_W-1:0] head,
    output logic [CNT_W-1:0]  fill
);
    typedef struct packed {
        logic [PTR_W-1:0] wp;
        logic [PTR_W-1:0] rp;
        logic [CNT_W-1:0] cnt;
    } wbuf_t;

    wbuf_t q, d;
    logic [DATA_W-1:0] mem [DEPTH];

    always_comb begin
        d = q;
        if (push) d.wp = (q.wp == PTR_W'(DEPTH - 1)) ? '0 : q.wp + 1'b1;
        if (pop)  d.rp = (q.rp == PTR_W'(DEPTH - 1)) ? '0 : q.rp + 1'b1;
        case ({push, pop})
            2'b10:   d.cnt = q.cnt + 1'b1;
            2'b01:   d.cnt = q.cnt - 1'b1;
            default: d.cnt = q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_ff @(posedge clk) begin
        if (push) mem[q.wp] <= push_data;
    end

    assign head = mem[q.rp];
    assign fill = q.cnt;

    // R12: the push side never writes into a full buffer
    assert_wbuf_no_overflow_R12: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (q.cnt < CNT_W'(DEPTH)));

    // R9: a data beat is only taken from a non-empty buffer
    assert_wbuf_no_underflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (q.cnt != '0));
endmodule

// File: rtl/tbm_len_calc.sv
module tbm_len_calc
    import tbm_pkg::*;
#(
    parameter int                ADDR_W    = 32,
    parameter int                DEPTH     = 8,
    parameter int                BYTE_SH   = 2,
    parameter logic [ADDR_W-1:0] BUF_BASE  = 32'h0000_1F00,
    parameter int                BUF_BYTES = 512,
    parameter int                CNT_W     = 4
) (
    input  logic [3:0]        cfg_len,
    input  logic              paged,
    input  logic              stopping,
    input  logic [CNT_W-1:0]  fill,
    input  logic [ADDR_W-1:0] addr,
    output logic              go,
    output logic [BEAT_W-1:0] beats
);
    localparam int                CAP_I   = (DEPTH > MAX_BEATS) ? MAX_BEATS : DEPTH;
    localparam logic [BEAT_W-1:0] CAP_MAX = BEAT_W'(CAP_I);
    localparam logic [ADDR_W-1:0] END_A   = BUF_BASE + ADDR_W'(BUF_BYTES);
    localparam logic [ADDR_W-1:0] PAGE_A  = ADDR_W'(PAGE_BYTES);
    localparam logic [ADDR_W-1:0] PAGE_M  = ADDR_W'(PAGE_BYTES - 1);

    logic [BEAT_W-1:0] prog, cap, room_clip, limit;
    logic [ADDR_W-1:0] room, room_beats;
    logic [15:0]       fill_x, limit_x;

    always_comb begin
        prog = {1'b0, cfg_len} + 1'b1;
        cap  = (prog > CAP_MAX) ? CAP_MAX : prog;

        if (paged) room = PAGE_A - (addr & PAGE_M);
        else       room = END_A - addr;
        room_beats = room >> BYTE_SH;
        room_clip  = (room_beats > ADDR_W'(MAX_BEATS)) ? BEAT_W'(MAX_BEATS)
                                                       : room_beats[BEAT_W-1:0];
        limit   = (room_clip < cap) ? room_clip : cap;
        fill_x  = 16'(fill);
        limit_x = 16'(limit);

        if (stopping) begin
            go    = (fill != '0);
            beats = (fill_x < limit_x) ? BEAT_W'(fill) : limit;
        end else begin
            go    = (fill_x >= limit_x);
            beats = limit;
        end
    end
endmodule

// File: rtl/tbuf_axi_burst_wr.sv
module tbuf_axi_burst_wr
    import tbm_pkg::*;
#(
    parameter int                DATA_W     = 32,
    parameter int                ADDR_W     = 32,
    parameter int                WBUF_DEPTH = 8,
    parameter logic [ADDR_W-1:0] BUF_BASE   = 32'h0000_1F00,
    parameter int                BUF_BYTES  = 512
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  capture_en,
    input  logic                  stop_req,
    input  logic [3:0]            cfg_burst_len,
    input  logic [3:0]            cfg_cache,
    input  logic [1:0]            cfg_prot,
    input  logic                  cfg_paged,
    input  logic                  in_valid,
    input  logic [DATA_W-1:0]     in_data,
    output logic                  in_ready,
    output logic                  awvalid,
    input  logic                  awready,
    output logic [ADDR_W-1:0]     awaddr,
    output logic [7:0]            awlen,
    output logic [2:0]            awsize,
    output logic [1:0]            awburst,
    output logic [3:0]            awcache,
    output logic [2:0]            awprot,
    output logic                  wvalid,
    input  logic                  wready,
    output logic [DATA_W-1:0]     wdata,
    output logic [DATA_W/8-1:0]   wstrb,
    output logic                  wlast,
    input  logic                  bvalid,
    output logic                  bready,
    output logic                  idle
);
    localparam int                BYTES = DATA_W / 8;
    localparam int                SZ    = $clog2(BYTES);
    localparam int                CNT_W = $clog2(WBUF_DEPTH + 1);
    localparam logic [ADDR_W-1:0] END_A = BUF_BASE + ADDR_W'(BUF_BYTES);

    typedef struct packed {
        tbm_state_e        state;
        logic [ADDR_W-1:0] addr;
        logic [BEAT_W-1:0] beats;
        logic [BEAT_W-1:0] beat_idx;
        logic [3:0]        len_cfg;
        logic [3:0]        cache;
        logic [1:0]        prot;
        logic              paged;
        logic              stop;
        logic              en_prev;
    } regs_t;

    regs_t q, d;

    logic              push, pop, go;
    logic [CNT_W-1:0]  fill;
    logic [BEAT_W-1:0] calc_beats;
    logic [ADDR_W-1:0] next_addr;
    logic              last_beat;

    tbm_wbuf #(
        .DATA_W (DATA_W),
        .DEPTH  (WBUF_DEPTH)
    ) u_wbuf (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_data (in_data),
        .pop       (pop),
        .head      (wdata),
        .fill      (fill)
    );

    tbm_len_calc #(
        .ADDR_W    (ADDR_W),
        .DEPTH     (WBUF_DEPTH),
        .BYTE_SH   (SZ),
        .BUF_BASE  (BUF_BASE),
        .BUF_BYTES (BUF_BYTES),
        .CNT_W     (CNT_W)
    ) u_len (
        .cfg_len  (q.len_cfg),
        .paged    (q.paged),
        .stopping (q.stop),
        .fill     (fill),
        .addr     (q.addr),
        .go       (go),
        .beats    (calc_beats)
    );

    assign last_beat = (q.beat_idx == q.beats - 1'b1);

    always_comb begin
        next_addr = q.addr + (ADDR_W'(q.beats) << SZ);
        if (!q.paged && next_addr == END_A) next_addr = BUF_BASE;
    end

    always_comb begin
        d         = q;
        d.en_prev = capture_en;
        if (q.state != ST_IDLE && stop_req) d.stop = 1'b1;

        case (q.state)
            ST_IDLE: begin
                if (capture_en && !q.en_prev) begin
                    d.state   = ST_RUN;
                    d.addr    = BUF_BASE;
                    d.len_cfg = cfg_burst_len;
                    d.cache   = cfg_cache;
                    d.prot    = cfg_prot;
                    d.paged   = cfg_paged;
                    d.stop    = 1'b0;
                end
            end
            ST_RUN: begin
                if (go) begin
                    d.beats = calc_beats;
                    d.state = ST_ADDR;
                end else if (q.stop && fill == '0) begin
                    d.state = ST_IDLE;
                end
            end
            ST_ADDR: begin
                if (awready) begin
                    d.state    = ST_DATA;
                    d.beat_idx = '0;
                end
            end
            ST_DATA: begin
                if (wready) begin
                    d.beat_idx = q.beat_idx + 1'b1;
                    if (last_beat) begin
                        d.state = ST_RESP;
                        d.addr  = next_addr;
                    end
                end
            end
            ST_RESP: begin
                if (bvalid) d.state = ST_RUN;
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign in_ready = (q.state != ST_IDLE) && !q.stop && (fill < CNT_W'(WBUF_DEPTH));
    assign push     = in_valid && in_ready;
    assign awvalid  = (q.state == ST_ADDR);
    assign awaddr   = q.addr;
    assign awlen    = 8'(q.beats - 1'b1);
    assign awsize   = 3'(SZ);
    assign awburst  = BURST_INCR;
    assign awcache  = q.cache;
    assign awprot   = {1'b0, q.prot};
    assign wvalid   = (q.state == ST_DATA);
    assign wstrb    = {BYTES{1'b1}};
    assign wlast    = last_beat;
    assign pop      = wvalid && wready;
    assign bready   = (q.state == ST_RESP);
    assign idle     = (q.state == ST_IDLE);

    // R8: stalled address channel keeps VALID and payload
    assert_aw_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        awvalid && !awready |=> awvalid && $stable(awaddr) && $stable(awlen)
                                && $stable(awcache) && $stable(awprot));

    // R8: stalled data channel keeps VALID, data and WLAST
    assert_w_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wvalid && !wready |=> wvalid && $stable(wdata) && $stable(wlast));

    // R2: burst length never exceeds the buffer depth
    assert_len_clamp_R2: assert property (@(posedge clk) disable iff (!rst_n)
        awvalid |-> (int'(awlen) < WBUF_DEPTH));

    // R3: the buffer holds every beat of a burst before it is announced
    assert_aw_backed_R3: assert property (@(posedge clk) disable iff (!rst_n)
        awvalid |-> (int'(fill) > int'(awlen)));

    // R7: after the last beat the block waits for the response, no new address
    assert_one_burst_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wvalid && wready && wlast |=> bready && !awvalid && !wvalid);

    // R11, R12: idle means no traffic and no intake
    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        idle |-> !awvalid && !wvalid && !in_ready);
endmodule

// File: tb/tbuf_axi_burst_wr_bench.sv
`timescale 1ns/1ps
module tbuf_axi_burst_wr_bench;
    localparam int          DEPTH = 8;
    localparam logic [31:0] BASE  = 32'h0000_1F00;
    localparam logic [31:0] M_END = 32'h0000_2100;
    localparam int          NVEC  = 8;
    localparam int          WDOG  = 150000;

    // {scramble, len, cache, prot, paged, words}
    localparam logic [23:0] VECS [NVEC] = '{
        {1'b0, 4'd0,  4'b0000, 2'b00, 1'b0, 12'd5},
        {1'b0, 4'd3,  4'b0011, 2'b01, 1'b0, 12'd10},
        {1'b0, 4'd15, 4'b1111, 2'b10, 1'b0, 12'd20},
        {1'b0, 4'd7,  4'b0110, 2'b11, 1'b0, 12'd16},
        {1'b0, 4'd2,  4'b0010, 2'b00, 1'b0, 12'd130},
        {1'b0, 4'd2,  4'b0000, 2'b01, 1'b1, 12'd70},
        {1'b1, 4'd1,  4'b0011, 2'b00, 1'b0, 12'd6},
        {1'b0, 4'd4,  4'b1011, 2'b10, 1'b0, 12'd0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        capture_en = 1'b0, stop_req = 1'b0;
    logic [3:0]  cfg_burst_len = '0, cfg_cache = '0;
    logic [1:0]  cfg_prot = '0;
    logic        cfg_paged = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_data = '0;
    logic        in_ready;
    logic        awvalid, awready = 1'b0;
    logic [31:0] awaddr;
    logic [7:0]  awlen;
    logic [2:0]  awsize, awprot;
    logic [1:0]  awburst;
    logic [3:0]  awcache, wstrb;
    logic        wvalid, wready = 1'b0, wlast;
    logic [31:0] wdata;
    logic        bvalid = 1'b0, bready, idle;

    always #10 clk = ~clk;

    tbuf_axi_burst_wr u_tbuf_axi_burst_wr (
        .clk(clk), .rst_n(rst_n), .capture_en(capture_en), .stop_req(stop_req),
        .cfg_burst_len(cfg_burst_len), .cfg_cache(cfg_cache), .cfg_prot(cfg_prot),
        .cfg_paged(cfg_paged), .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
        .awvalid(awvalid), .awready(awready), .awaddr(awaddr), .awlen(awlen),
        .awsize(awsize), .awburst(awburst), .awcache(awcache), .awprot(awprot),
        .wvalid(wvalid), .wready(wready), .wdata(wdata), .wstrb(wstrb), .wlast(wlast),
        .bvalid(bvalid), .bready(bready), .idle(idle)
    );

    int          cyc = 0, total = 0, bad = 0, push_left = 0, b_delay = 0;
    int          m_rem = 0, m_len = 0, cur_beats = 0, w_idx = 0;
    logic [31:0] push_val = '0, w_exp = '0, m_addr = '0, aw_hold_addr = '0, w_hold_data = '0;
    logic [3:0]  m_cache = '0;
    logic [1:0]  m_prot = '0;
    bit          m_paged = 0, b_done = 0, outstanding = 0, timed_out = 0;
    bit          aw_stall = 0, w_stall = 0;
    string       tag_len = "R1", tag_attr = "R5";

    task automatic check_eq(string req, logic [63:0] act, logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] word(logic [31:0] n);
        return n ^ 32'h5A5A_0000;
    endfunction

    task automatic on_aw();
        int cap, room, lim, b;
        cap  = (m_len + 1 < DEPTH) ? m_len + 1 : DEPTH;
        room = m_paged ? (4096 - int'(m_addr % 4096)) / 4 : int'(M_END - m_addr) / 4;
        lim  = (cap < room) ? cap : room;
        b    = (lim < m_rem) ? lim : m_rem;
        check_eq("R7 single outstanding", 64'(outstanding), 64'd0);
        check_eq("R6 address", 64'(awaddr), 64'(m_addr));
        check_eq(tag_len, 64'(awlen) + 1, 64'(b));
        check_eq(tag_attr, {awcache, awprot}, {m_cache, 1'b0, m_prot});
        check_eq("R5 size/burst", {awsize, awburst}, {3'd2, 2'b01});
        outstanding = 1;
        cur_beats   = int'(awlen) + 1;
        w_idx       = 0;
        m_addr      = m_addr + 32'(4 * b);
        if (!m_paged && m_addr == M_END) m_addr = BASE;
        m_rem = m_rem - b;
    endtask

    task automatic cycle();
        @(negedge clk);
        cyc++;
        if (cyc >= WDOG) timed_out = 1;
        awready = (cyc % 3) != 0;
        wready  = (cyc % 4) != 1;
        if (b_done) begin bvalid = 1'b0; b_done = 0; end
        if (b_delay > 0) begin
            b_delay--;
            if (b_delay == 0) bvalid = 1'b1;
        end
        in_valid = (push_left > 0);
        in_data  = word(push_val);
        #1;
        if (in_valid && in_ready) begin push_val++; push_left--; end
        if (aw_stall) check_eq("R8 aw held", {awvalid, awaddr}, {1'b1, aw_hold_addr});
        if (w_stall)  check_eq("R8 w held", {wvalid, wdata}, {1'b1, w_hold_data});
        aw_stall     = awvalid && !awready;
        aw_hold_addr = awaddr;
        w_stall      = wvalid && !wready;
        w_hold_data  = wdata;
        if (awvalid && awready) on_aw();
        if (wvalid && wready) begin
            check_eq("R9 data order", 64'(wdata), 64'(word(w_exp)));
            check_eq("R9 wlast", 64'(wlast), 64'(w_idx == cur_beats - 1));
            w_exp++;
            w_idx++;
            if (wlast) b_delay = 2;
        end
        if (bvalid && bready) begin outstanding = 0; b_done = 1; end
    endtask

    task automatic run_vec(int i);
        logic [23:0] v;
        v             = VECS[i];
        cfg_burst_len = v[22:19];
        cfg_cache     = v[18:15];
        cfg_prot      = v[14:13];
        cfg_paged     = v[12];
        m_len         = int'(v[22:19]);
        m_cache       = v[18:15];
        m_prot        = v[14:13];
        m_paged       = v[12];
        m_rem         = int'(v[11:0]);
        m_addr        = BASE;
        case (i)
            2:       tag_len = "R2 clamp";
            4:       tag_len = "R6 ring length";
            5:       tag_len = "R3 page cut";
            1, 7:    tag_len = "R4 flush";
            6:       tag_len = "R10 length";
            default: tag_len = "R1 length";
        endcase
        tag_attr = v[23] ? "R10 attributes" : "R5 attributes";
        capture_en = 1'b1;
        cycle();
        cycle();
        check_eq("R11 busy after enable", 64'(idle), 64'd0);
        if (v[23]) begin
            cfg_burst_len = 4'hF; cfg_cache = 4'hF; cfg_prot = 2'b11; cfg_paged = 1'b1;
        end
        push_left = int'(v[11:0]);
        while (push_left > 0 && !timed_out) cycle();
        stop_req = 1'b1;
        cycle();
        stop_req = 1'b0;
        check_eq("R12 intake closed after stop", 64'(in_ready), 64'd0);
        while (!idle && !timed_out) cycle();
        check_eq("R4 all data flushed", 64'(m_rem), 64'd0);
        check_eq("R11 idle after flush", {idle, outstanding}, {1'b1, 1'b0});
        capture_en = 1'b0;
        cycle();
        cycle();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check_eq("R11 idle in reset", 64'(idle), 64'd1);
        check_eq("R5 attributes in reset", {awcache, awprot}, 64'd0);
        check_eq("R12 no intake in reset", {in_ready, awvalid, wvalid}, 64'd0);
        rst_n = 1'b1;
        cycle();

        // idle stretch: settings toggle, pushes offered, no capture enable
        push_left = 3;
        for (int k = 0; k < 20; k++) begin
            cfg_burst_len = 4'(k);
            cfg_cache     = 4'(k);
            cycle();
            if (in_ready || awvalid) check_eq("R10 idle quiet", {in_ready, awvalid}, 64'd0);
        end
        check_eq("R12 nothing accepted while idle", 64'(push_left), 64'd3);
        check_eq("R10 no traffic while idle", {awvalid, wvalid, idle}, {1'b0, 1'b0, 1'b1});
        push_left = 0;
        cycle();

        for (int i = 0; i < NVEC; i++) begin
            if (!timed_out) run_vec(i);
        end
        check_eq("R9 every word written", 64'(w_exp), 64'(push_val));

        if (timed_out) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=<%0d", cyc, WDOG);
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule